// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel has a low byte, a high byte and a small control register. A channel advances on a one-cycle internal tick pulse or on a falling edge of its external count pin. The pin is first synchronized to the clock. A two-bit mode field picks the channel's structure. Mode 0 is a 13-bit count in which the low byte's bottom five bits act as a prescaler for the high byte. Mode 1 is a full 16-bit cascade. Mode 2 is an 8-bit low-byte counter that reloads from the high byte. Mode 3 splits channel 0 into two independent 8-bit counters.

Each channel has a run bit and a gate bit. When the gate bit is set, the channel counts only while its synchronized interrupt pin is high. This lets an external signal measure a pulse width. Overflows set one sticky flag per channel. A vector-acknowledge input clears a flag, and a direct write can also clear it. In split mode, channel 0's high byte takes channel 1's run bit and channel 1's overflow flag. Channel 1 stops when it is placed in mode 3 itself.

A single write port loads any counter byte, either control register or the flag pair. The asynchronous reset is released through a two-flop synchronizer before any state leaves reset.

Top module: `tmr_pair`

## Requirements
- R1: A channel steps only when its control run bit (bit 0) is 1 and either its gate bit (bit 1) is 0 or its synchronized irq_pin bit is 1. Otherwise both of its bytes hold.
- R2: Control bit 2 picks the count source. A 1 counts synchronized falling edges of cnt_pin, one step per 1-to-0 transition, and ignores tick. A 0 counts clock cycles in which tick is 1.
- R3: Mode 0 (control bits 4:3 = 00) forms a 13-bit value {hi, lo[4:0]}. It wraps from 0x1FFF to 0, and that wrap sets the channel's flag. lo[7:5] are never changed by a step.
- R4: Mode 1 (bits 4:3 = 01) steps {hi, lo} as a 16-bit count. The wrap from 0xFFFF to 0 sets the flag.
- R5: Mode 2 (bits 4:3 = 10) steps lo only. When lo is 0xFF, a step loads lo from hi and sets the flag. hi is unchanged.
- R6: With channel 0 in mode 3, ch0_lo is an 8-bit counter under channel 0's controls and sets flag 0 on wrap. ch0_hi steps on tick whenever channel 1's run bit is 1 and sets flag 1 on wrap. Channel 1 keeps counting under its own controls, but its overflows no longer set flag 1.
- R7: Channel 1 in mode 3 holds both of its bytes regardless of run, gate, tick or pins.
- R8: A flag is set by its overflow and cleared by a 1 on its ack bit. If a set and an ack occur in the same cycle, the set wins.
- R9: A write to the flag register (wr_sel = 6, bit 0 for channel 0, bit 1 for channel 1) loads both flags and overrides any set or ack in that cycle.
- R10: A byte write (wr_sel 0 = ch0_lo, 1 = ch0_hi, 2 = ch1_lo, 3 = ch1_hi) cancels the step of the counter that byte belongs to in that cycle. In modes 0 to 2, that counter is the whole channel. In split mode, ch0_lo and ch0_hi are separate counters. Control writes use wr_sel 4 and 5 and take effect in the next cycle.
- R11: After reset, all counter bytes, both flags and both control registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Internal count pulse |
| cnt_pin | input | 2 | External count pins, one per channel (asynchronous) |
| irq_pin | input | 2 | Gate pins, one per channel (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 8 | Write data |
| ack | input | 2 | Vector acknowledge, clears the matching flag |
| ch0_lo | output | 8 | Channel 0 low byte |
| ch0_hi | output | 8 | Channel 0 high byte |
| ch1_lo | output | 8 | Channel 1 low byte |
| ch1_hi | output | 8 | Channel 1 high byte |
| ovf | output | 2 | Overflow flags |

## Verification
Two pairs of events can land on the same clock edge. The first pair is an overflow and a flag acknowledge, or an overflow and a flag write. The second pair is a counting step and a write to a counter byte. The bench raises tick in the very cycle that it pulses ack, writes the flags, or loads a byte. It then judges the outcome from the next flag and byte values against the R8, R9 and R10 priority rules, including the split-mode case in which a low-byte write must not stop the high byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH   = 2;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    MODE_PRE13   = 2'd0,
    MODE_CAS16   = 2'd1,
    MODE_RELOAD8 = 2'd2,
    MODE_SPLIT   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    tmr_mode_e mode;
    logic      src;
    logic      gate;
    logic      run;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [SEL_W-1:0] SEL_LO0  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_HI0  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_LO1  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_HI1  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CTL0 = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CTL1 = 3'd5;
  localparam logic [SEL_W-1:0] SEL_FLAG = 3'd6;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W        = 8,
  parameter int PRE      = 5,
  parameter bit SPLIT_HI = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  logic         step_lo,
  input  logic         step_hi,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf_main,
  output logic         ovf_split
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0]   W_ONE   = W'(1);
  localparam logic [PRE-1:0] PRE_ONE = PRE'(1);
  localparam logic [DW-1:0]  DW_ONE  = DW'(1);

  logic [W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic         split, lo_blk, hi_blk;

  always_comb begin
    split     = (mode == MODE_SPLIT);
    lo_blk    = wr_lo | (~split & wr_hi);
    hi_blk    = wr_hi | (~split & wr_lo);
    lo_n      = lo_q;
    hi_n      = hi_q;
    ovf_main  = 1'b0;
    ovf_split = 1'b0;
    unique case (mode)
      MODE_PRE13: begin
        if (step_lo && !lo_blk) begin
          if (&lo_q[PRE-1:0]) begin
            lo_n[PRE-1:0] = '0;
            hi_n          = hi_q + W_ONE;
            ovf_main      = &hi_q;
          end else begin
            lo_n[PRE-1:0] = lo_q[PRE-1:0] + PRE_ONE;
          end
        end
      end
      MODE_CAS16: begin
        if (step_lo && !lo_blk) begin
          {hi_n, lo_n} = {hi_q, lo_q} + DW_ONE;
          ovf_main     = &{hi_q, lo_q};
        end
      end
      MODE_RELOAD8: begin
        if (step_lo && !lo_blk) begin
          if (&lo_q) begin
            lo_n     = hi_q;
            ovf_main = 1'b1;
          end else begin
            lo_n = lo_q + W_ONE;
          end
        end
      end
      MODE_SPLIT: begin
        if (SPLIT_HI) begin
          if (step_lo && !lo_blk) begin
            lo_n     = lo_q + W_ONE;
            ovf_main = &lo_q;
          end
          if (step_hi && !hi_blk) begin
            hi_n      = hi_q + W_ONE;
            ovf_split = &hi_q;
          end
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int W   = 8,
  parameter int PRE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       cnt_pin,
  input  logic [1:0]       irq_pin,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic [1:0]       ack,
  output logic [W-1:0]     ch0_lo,
  output logic [W-1:0]     ch0_hi,
  output logic [W-1:0]     ch1_lo,
  output logic [W-1:0]     ch1_hi,
  output logic [1:0]       ovf
);
  logic          srst_n;
  logic [3:0]    pins_s;
  logic [1:0]    cnt_s, irq_s, cnt_prev_q, cnt_fall;
  tmr_ctrl_t     ctrl0_q, ctrl1_q, ctrl0_n, ctrl1_n;
  logic [1:0]    flag_q, flag_n, set_flag;
  logic          run0, run1, evt0, evt1, split_step;
  logic          c0_ovf_main, c0_ovf_split, c1_ovf_main, c1_ovf_split;
  logic          wr_flag;

  tmr_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  tmr_sync #(.N(4), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(srst_n), .din({irq_pin, cnt_pin}), .dout(pins_s)
  );

  assign cnt_s    = pins_s[1:0];
  assign irq_s    = pins_s[3:2];
  assign cnt_fall = cnt_prev_q & ~cnt_s;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_prev_q <= '0;
    else         cnt_prev_q <= cnt_s;
  end

  // Count-event qualification
  always_comb begin
    run0       = ctrl0_q.run & (~ctrl0_q.gate | irq_s[0]);
    run1       = ctrl1_q.run & (~ctrl1_q.gate | irq_s[1]);
    evt0       = run0 & (ctrl0_q.src ? cnt_fall[0] : tick);
    evt1       = run1 & (ctrl1_q.src ? cnt_fall[1] : tick);
    split_step = ctrl1_q.run & tick;
  end

  tmr_chan #(.W(W), .PRE(PRE), .SPLIT_HI(1'b1)) u_ch0 (
    .clk(clk), .rst_n(srst_n), .mode(ctrl0_q.mode),
    .step_lo(evt0), .step_hi(split_step),
    .wr_lo(wr_en && wr_sel == SEL_LO0), .wr_hi(wr_en && wr_sel == SEL_HI0),
    .wdata(wr_data), .lo(ch0_lo), .hi(ch0_hi),
    .ovf_main(c0_ovf_main), .ovf_split(c0_ovf_split)
  );

  tmr_chan #(.W(W), .PRE(PRE), .SPLIT_HI(1'b0)) u_ch1 (
    .clk(clk), .rst_n(srst_n), .mode(ctrl1_q.mode),
    .step_lo(evt1), .step_hi(1'b0),
    .wr_lo(wr_en && wr_sel == SEL_LO1), .wr_hi(wr_en && wr_sel == SEL_HI1),
    .wdata(wr_data), .lo(ch1_lo), .hi(ch1_hi),
    .ovf_main(c1_ovf_main), .ovf_split(c1_ovf_split)
  );

  // Control and flag next state
  always_comb begin
    ctrl0_n = ctrl0_q;
    ctrl1_n = ctrl1_q;
    if (wr_en && wr_sel == SEL_CTL0) ctrl0_n = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
    if (wr_en && wr_sel == SEL_CTL1) ctrl1_n = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);

    set_flag[0] = c0_ovf_main;
    set_flag[1] = (ctrl0_q.mode == MODE_SPLIT) ? c0_ovf_split
                                               : (c1_ovf_main | c1_ovf_split);
    wr_flag = wr_en && wr_sel == SEL_FLAG;
    for (int i = 0; i < NCH; i++) begin
      if (wr_flag)          flag_n[i] = wr_data[i];
      else if (set_flag[i]) flag_n[i] = 1'b1;
      else if (ack[i])      flag_n[i] = 1'b0;
      else                  flag_n[i] = flag_q[i];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      flag_q  <= '0;
    end else begin
      ctrl0_q <= ctrl0_n;
      ctrl1_q <= ctrl1_n;
      flag_q  <= flag_n;
    end
  end

  assign ovf = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [7:0]       wr_data,
  input logic [1:0]       ack,
  input logic [1:0]       ovf,
  input logic [1:0]       set_flag,
  input tmr_ctrl_t        ctrl0,
  input tmr_ctrl_t        ctrl1,
  input logic [7:0]       ch0_lo,
  input logic [7:0]       ch0_hi,
  input logic [7:0]       ch1_lo,
  input logic [7:0]       ch1_hi
);
  logic wr_flag, wr_c0, wr_c1;
  assign wr_flag = wr_en && wr_sel == SEL_FLAG;
  assign wr_c0   = wr_en && (wr_sel == SEL_LO0 || wr_sel == SEL_HI0);
  assign wr_c1   = wr_en && (wr_sel == SEL_LO1 || wr_sel == SEL_HI1);

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl0.run && ctrl0.mode != MODE_SPLIT && !wr_c0) |=> ($stable(ch0_lo) && $stable(ch0_hi))); // R1

  AST_CH1_SPLIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl1.mode == MODE_SPLIT && !wr_c1) |=> ($stable(ch1_lo) && $stable(ch1_hi))); // R7

  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flag[0] && !wr_flag) |=> ovf[0]); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[1] && !set_flag[1] && !wr_flag) |=> !ovf[1]); // R8

  AST_FLAG_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> (ovf == $past(wr_data[1:0]))); // R9
endmodule

bind tmr_pair tmr_pair_chk i_chk (
  .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ack(ack), .ovf(ovf), .set_flag(set_flag), .ctrl0(ctrl0_q), .ctrl1(ctrl1_q),
  .ch0_lo(ch0_lo), .ch0_hi(ch0_hi), .ch1_lo(ch1_lo), .ch1_hi(ch1_hi)
);

// File: tb/test_tmr_pair.sv
module test_tmr_pair;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, tick, wr_en;
  logic [1:0] cnt_pin, irq_pin, ack;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] ch0_lo, ch0_hi, ch1_lo, ch1_hi;
  logic [1:0] ovf;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pair i_tmr_pair (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .irq_pin(irq_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ack(ack),
    .ch0_lo(ch0_lo), .ch0_hi(ch0_hi), .ch1_lo(ch1_lo), .ch1_hi(ch1_hi), .ovf(ovf)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d, input logic t);
    wr_en = 1'b1; wr_sel = s; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setup(input logic [7:0] c0, input logic [7:0] c1,
                       input logic [7:0] l0, input logic [7:0] h0,
                       input logic [7:0] l1, input logic [7:0] h1);
    wr(3'd4, 8'h00, 1'b0); wr(3'd5, 8'h00, 1'b0);
    wr(3'd0, l0, 1'b0); wr(3'd1, h0, 1'b0);
    wr(3'd2, l1, 1'b0); wr(3'd3, h1, 1'b0);
    wr(3'd6, 8'h00, 1'b0);
    wr(3'd4, c0, 1'b0); wr(3'd5, c1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hs[3]  = '{0, 0, 255};
    int ps[3]  = '{0, 30, 31};
    int ns[3]  = '{1, 3, 40};
    int s16[3] = '{32'h0000, 32'h00FE, 32'hFFF0};
    int m2l[3] = '{8'hF0, 8'hFE, 8'h00};
    int m2h[3] = '{8'h10, 8'hC0, 8'h00};
    int m2n[3] = '{5, 20, 300};

    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    ack = '0; cnt_pin = 2'b11; irq_pin = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 ch0", {ch0_hi, ch0_lo}, 0);
    chk("R11 ch1", {ch1_hi, ch1_lo}, 0);
    chk("R11 ovf", ovf, 0);
    ticks(5);
    chk("R11 ctrl cleared, no count", {ch0_hi, ch0_lo, ch1_hi, ch1_lo}, 0);

    // R3 mode 0 sweep
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        int v;
        v = (hs[a] << 5) + ps[a] + ns[b];
        setup(8'h01, 8'h00, 8'hE0 | 8'(ps[a]), 8'(hs[a]), 8'h00, 8'h00);
        ticks(ns[b]);
        chk("R3 lo", ch0_lo, 8'hE0 | (v & 31));
        chk("R3 hi", ch0_hi, (v >> 5) & 255);
        chk("R3 flag", ovf[0], v >= 8192 ? 1 : 0);
      end
    end

    // R4 mode 1 sweep
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        int v;
        v = s16[a] + ns[b];
        setup(8'h09, 8'h00, 8'(s16[a]), 8'(s16[a] >> 8), 8'h00, 8'h00);
        ticks(ns[b]);
        chk("R4 count", {ch0_hi, ch0_lo}, v & 16'hFFFF);
        chk("R4 flag", ovf[0], v > 16'hFFFF ? 1 : 0);
      end
    end

    // R5 mode 2 sweep (on channel 1)
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        int lo, f;
        lo = m2l[a]; f = 0;
        for (int i = 0; i < m2n[b]; i++) begin
          if (lo == 255) begin lo = m2h[a]; f = 1; end
          else lo = lo + 1;
        end
        setup(8'h00, 8'h11, 8'h00, 8'h00, 8'(m2l[a]), 8'(m2h[a]));
        ticks(m2n[b]);
        chk("R5 lo", ch1_lo, lo);
        chk("R5 hi", ch1_hi, m2h[a]);
        chk("R5 flag", ovf[1], f);
      end
    end

    // R1 run bit off
    setup(8'h08, 8'h00, 8'h10, 8'h20, 8'h00, 8'h00);
    ticks(10);
    chk("R1 stopped", {ch0_hi, ch0_lo}, 16'h2010);
    // R1 gate low blocks, gate high counts
    irq_pin[0] = 1'b0;
    setup(8'h0B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    ticks(10);
    chk("R1 gated low", {ch0_hi, ch0_lo}, 0);
    irq_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    ticks(10);
    chk("R1 gated high", {ch0_hi, ch0_lo}, 10);

    // R2 external source, tick ignored
    for (int k = 1; k <= 5; k += 2) begin
      setup(8'h0D, 8'h0D, 8'h00, 8'h00, 8'h00, 8'h00);
      tick = 1'b1;
      for (int p = 0; p < k; p++) begin
        cnt_pin = 2'b00; repeat (3) @(negedge clk);
        cnt_pin = 2'b11; repeat (3) @(negedge clk);
      end
      repeat (5) @(negedge clk);
      tick = 1'b0;
      chk("R2 ch0 edges", {ch0_hi, ch0_lo}, k);
      chk("R2 ch1 edges", {ch1_hi, ch1_lo}, k);
    end

    // R6 split mode
    setup(8'h19, 8'h09, 8'hFC, 8'h00, 8'hFE, 8'hFF);
    ticks(6);
    chk("R6 lo0", ch0_lo, 8'h02);
    chk("R6 hi0", ch0_hi, 8'h06);
    chk("R6 ch1 counts", {ch1_hi, ch1_lo}, 16'h0004);
    chk("R6 flags (ch1 wrap masked)", ovf, 2'b01);
    setup(8'h19, 8'h08, 8'h00, 8'hFE, 8'h00, 8'h00);
    ticks(6);
    chk("R6 hi0 needs ch1 run", ch0_hi, 8'hFE);
    chk("R6 lo0 own run", ch0_lo, 8'h06);
    setup(8'h19, 8'h09, 8'h00, 8'hFE, 8'h00, 8'h00);
    ticks(6);
    chk("R6 hi0 wraps", ch0_hi, 8'h04);
    chk("R6 hi0 sets flag1", ovf, 2'b10);

    // R7 channel 1 in mode 3 holds
    setup(8'h00, 8'h19, 8'h00, 8'h00, 8'h34, 8'h12);
    ticks(20);
    chk("R7 ch1 hold", {ch1_hi, ch1_lo}, 16'h1234);

    // R8 set, ack, collision
    setup(8'h09, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00);
    ticks(1);
    chk("R8 set", ovf[0], 1);
    ack = 2'b01; @(negedge clk); ack = 2'b00;
    chk("R8 ack clears", ovf[0], 0);
    setup(8'h09, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00);
    wr(3'd6, 8'h01, 1'b0);
    ack = 2'b01; tick = 1'b1; @(negedge clk); ack = 2'b00; tick = 1'b0;
    chk("R8 set wins over ack", ovf[0], 1);

    // R9 flag write overrides overflow
    setup(8'h09, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00);
    wr(3'd6, 8'h00, 1'b1);
    chk("R9 write beats set", ovf[0], 0);
    chk("R9 counter still wrapped", {ch0_hi, ch0_lo}, 0);

    // R10 write cancels step
    setup(8'h09, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00);
    wr(3'd0, 8'h55, 1'b1);
    chk("R10 write wins", {ch0_hi, ch0_lo}, 16'h0055);
    ticks(1);
    chk("R10 resumes", {ch0_hi, ch0_lo}, 16'h0056);
    setup(8'h19, 8'h09, 8'h00, 8'h00, 8'h00, 8'h00);
    wr(3'd0, 8'h55, 1'b1);
    chk("R10 split lo write", ch0_lo, 8'h55);
    chk("R10 split hi unaffected", ch0_hi, 8'h01);

    finish_run();
  end
endmodule